// File: doc/BRIEF.md
# Hierarchical Super-Tile Address Generator

This block turns a pixel coordinate into the byte address of that pixel in a framebuffer held in nested tiles. The smallest unit is a 4x4-pixel tile. Two such tiles across and four down form a group. Eight groups across and four down fill a 64x64-pixel super-tile. Each level is stored in row-major order, and super-tiles run row-major across a surface whose width is given as a count of super-tiles. A flat tiled layout is also available. In that layout the 4x4 tiles run row-major across the whole surface and there is no group or super-tile level.

A second layout switch splits the surface over two memory pipes. In split mode the tiles of the chosen layout alternate between two base addresses, and the offset from each base shrinks to half. The element size can be 1, 2 or 4 bytes. Each request carries its coordinate and the whole layout configuration, so consecutive requests can use different surfaces. Requests enter through a valid/ready handshake. Each request passes through two register stages and comes out as one registered address, in order.

Top module: `stile_addr_gen`

## Requirements
- R1: Within a 4x4 tile, the pixel at column px and row py (each 0..3) has tile-local index py*4+px.
- R2: With in_super=1, the pixel index is S*4096 + G*128 + T*16 + P. Here S = (y/64)*in_wst + x/64, G = ((y%64)/16)*8 + (x%64)/8, T = ((y%16)/4)*2 + (x%8)/4, and P is the R1 index.
- R3: With in_super=0, the pixel index is ((y/4)*in_wst*16 + x/4)*16 + P.
- R4: With in_split=1, the tile number N = index/16 selects in_base1 when N is odd and in_base0 when N is even. The element offset is (N/2)*16 + P. With in_split=0, in_base0 is used with the full index.
- R5: in_bpp encodes the element size: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The address is the selected base plus the element offset times the size, modulo 2^32.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_addr does not change.
- R7: A request is taken on a rising edge where in_valid and in_ready are both high. in_ready is low exactly when two requests are outstanding and out_ready is low. Results leave in acceptance order, one per request.
- R8: out_valid is high exactly when the oldest outstanding request was taken at least two rising edges earlier. With out_ready held high, each address appears after the second rising edge following acceptance.
- R9: During reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_x | input | 14 | Pixel column |
| in_y | input | 14 | Pixel row |
| in_wst | input | 8 | Surface width in 64-pixel super-tiles |
| in_super | input | 1 | 1: nested super-tile layout, 0: flat 4x4 tiled layout |
| in_split | input | 1 | 1: alternate tiles over two bases with halved offsets |
| in_bpp | input | 2 | Element size code |
| in_base0 | input | 32 | Base address of the first pipe |
| in_base1 | input | 32 | Base address of the second pipe |
| out_valid | output | 1 | Address present |
| out_ready | input | 1 | Address taken |
| out_addr | output | 32 | Byte address |

## Verification
The bench samples every cycle in the low half of the clock and keeps a queue of accepted requests, each stamped with its acceptance cycle. From that queue it predicts the cycle in which each address is due. out_valid must be high exactly when the head of the queue is two or more cycles old. in_ready must be low exactly when two requests are queued while out_ready is low. Every address handed over is compared with a model that walks super-tiles, groups, tiles and pixels in nested loops. A stalled output must hold the same value until the next cycle in which out_ready is high.

// File: rtl/stile_pkg.sv
package stile_pkg;
  localparam int TILE_LOG = 2;
  localparam int ST_LOG   = 6;
  localparam int ST_PIX_LOG = 2 * ST_LOG;
  localparam int TILE_PIX_LOG = 2 * TILE_LOG;

  typedef enum logic [1:0] {
    ESZ_1  = 2'd0,
    ESZ_2  = 2'd1,
    ESZ_4  = 2'd2,
    ESZ_4B = 2'd3
  } esz_e;

  function automatic logic [1:0] esz_shift(input logic [1:0] code);
    case (esz_e'(code))
      ESZ_1:   esz_shift = 2'd0;
      ESZ_2:   esz_shift = 2'd1;
      default: esz_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/stile_stage.sv
module stile_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         v_d,
  input  logic [W-1:0] d,
  output logic         v_q,
  output logic [W-1:0] q
);
  logic         v_nxt;
  logic [W-1:0] q_nxt;

  always_comb begin
    v_nxt = v_q;
    q_nxt = q;
    if (ld) begin
      v_nxt = v_d;
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_nxt;
  end

  always_ff @(posedge clk) begin
    if (ld) q <= q_nxt;
  end
endmodule

// File: rtl/stile_index.sv
module stile_index
  import stile_pkg::*;
#(
  parameter int X_W   = 14,
  parameter int Y_W   = 14,
  parameter int WST_W = 8,
  parameter int IDX_W = 29
) (
  input  logic [X_W-1:0]   x,
  input  logic [Y_W-1:0]   y,
  input  logic [WST_W-1:0] wst,
  input  logic             super_en,
  output logic [IDX_W-1:0] idx
);
  localparam int ROW_TILE_LOG = ST_LOG - TILE_LOG;

  logic [IDX_W-1:0] st_num, idx_st, row_tiles, tile_num, idx_flat;
  logic [ST_PIX_LOG-1:0] st_local;
  logic [TILE_PIX_LOG-1:0] in_tile;

  always_comb begin
    in_tile  = {y[1:0], x[1:0]};
    st_local = {y[5:4], x[5:3], y[3:2], x[2], in_tile};
    st_num   = IDX_W'(y[Y_W-1:ST_LOG]) * IDX_W'(wst) + IDX_W'(x[X_W-1:ST_LOG]);
    idx_st   = (st_num << ST_PIX_LOG) | IDX_W'(st_local);
    row_tiles = IDX_W'(wst) << ROW_TILE_LOG;
    tile_num = IDX_W'(y[Y_W-1:TILE_LOG]) * row_tiles + IDX_W'(x[X_W-1:TILE_LOG]);
    idx_flat = (tile_num << TILE_PIX_LOG) | IDX_W'(in_tile);
    idx      = super_en ? idx_st : idx_flat;
  end
endmodule

// File: rtl/stile_addr.sv
module stile_addr
  import stile_pkg::*;
#(
  parameter int IDX_W  = 29,
  parameter int ADDR_W = 32
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              split,
  input  logic [1:0]        esz,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] base1,
  output logic [ADDR_W-1:0] addr
);
  localparam int OFF_W = IDX_W + 2;

  logic [IDX_W-1:0] eff;
  logic [OFF_W-1:0] off;
  logic             odd_tile;

  always_comb begin
    odd_tile = idx[TILE_PIX_LOG];
    if (split)
      eff = ((idx >> (TILE_PIX_LOG + 1)) << TILE_PIX_LOG) | IDX_W'(idx[TILE_PIX_LOG-1:0]);
    else
      eff = idx;
    off  = OFF_W'(eff) << esz_shift(esz);
    addr = ((split && odd_tile) ? base1 : base0) + ADDR_W'(off);
  end
endmodule

// File: rtl/stile_addr_gen.sv
module stile_addr_gen
  import stile_pkg::*;
#(
  parameter int X_W    = 14,
  parameter int Y_W    = 14,
  parameter int WST_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [X_W-1:0]    in_x,
  input  logic [Y_W-1:0]    in_y,
  input  logic [WST_W-1:0]  in_wst,
  input  logic              in_super,
  input  logic              in_split,
  input  logic [1:0]        in_bpp,
  input  logic [ADDR_W-1:0] in_base0,
  input  logic [ADDR_W-1:0] in_base1,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int IDX_W = Y_W + WST_W + 7;
  localparam int S1_W  = IDX_W + 3 + 2 * ADDR_W;

  logic [IDX_W-1:0]  idx_c, s1_idx;
  logic [S1_W-1:0]   s1_d, s1_q;
  logic              s1_v, s1_en, s2_en, s1_split;
  logic [1:0]        s1_esz;
  logic [ADDR_W-1:0] s1_b0, s1_b1, addr_c;

  // stage enables: stage 2 moves when empty or drained, stage 1 when stage 2 moves or empty
  always_comb begin
    s2_en    = !out_valid || out_ready;
    s1_en    = s2_en || !s1_v;
    in_ready = s1_en;
  end

  stile_index #(.X_W(X_W), .Y_W(Y_W), .WST_W(WST_W), .IDX_W(IDX_W)) u_index (
    .x(in_x), .y(in_y), .wst(in_wst), .super_en(in_super), .idx(idx_c)
  );

  assign s1_d = {idx_c, in_split, in_bpp, in_base1, in_base0};

  stile_stage #(.W(S1_W)) u_s1 (
    .clk(clk), .rst_n(rst_n), .ld(s1_en), .v_d(in_valid), .d(s1_d),
    .v_q(s1_v), .q(s1_q)
  );

  assign {s1_idx, s1_split, s1_esz, s1_b1, s1_b0} = s1_q;

  stile_addr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_addr (
    .idx(s1_idx), .split(s1_split), .esz(s1_esz), .base0(s1_b0), .base1(s1_b1),
    .addr(addr_c)
  );

  stile_stage #(.W(ADDR_W)) u_s2 (
    .clk(clk), .rst_n(rst_n), .ld(s2_en), .v_d(s1_v), .d(addr_c),
    .v_q(out_valid), .q(out_addr)
  );

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  p_stall_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && !in_ready |=> s1_v && $stable(s1_q));

  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_v);

  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && (!out_valid || out_ready) |=> out_valid);
endmodule

// File: tb/tb_stile_addr_gen.sv
module tb_stile_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_super, in_split, out_valid, out_ready;
  logic [13:0] in_x, in_y;
  logic [7:0]  in_wst;
  logic [1:0]  in_bpp;
  logic [31:0] in_base0, in_base1, out_addr;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit rdy_rand = 0, rdy_force = 1, mon_on = 0, hold_prev = 0;
  logic [31:0] prev_addr;
  string tag_cur = "R2";
  logic [31:0] exp_q[$];
  int          acc_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  stile_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_wst(in_wst), .in_super(in_super),
    .in_split(in_split), .in_bpp(in_bpp), .in_base0(in_base0), .in_base1(in_base1),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  function automatic logic [31:0] model(int x, int y, int wst, bit sup, bit spl,
                                        int bpp, logic [31:0] b0, logic [31:0] b1);
    int n = 0, idx = 0, tn, eidx, sz;
    bit f = 0;
    logic [31:0] b;
    if (sup) begin
      for (int sy = 0; sy < 64 && !f; sy++)
        for (int sx = 0; sx < wst && !f; sx++)
          for (int gy = 0; gy < 4 && !f; gy++)
            for (int gx = 0; gx < 8 && !f; gx++)
              for (int ty = 0; ty < 4 && !f; ty++)
                for (int tx = 0; tx < 2 && !f; tx++)
                  for (int py = 0; py < 4 && !f; py++)
                    for (int px = 0; px < 4 && !f; px++) begin
                      if (sx*64 + gx*8 + tx*4 + px == x && sy*64 + gy*16 + ty*4 + py == y) begin
                        idx = n; f = 1;
                      end
                      n++;
                    end
    end else begin
      for (int tr = 0; tr < 1024 && !f; tr++)
        for (int tc = 0; tc < wst*16 && !f; tc++)
          for (int py = 0; py < 4 && !f; py++)
            for (int px = 0; px < 4 && !f; px++) begin
              if (tc*4 + px == x && tr*4 + py == y) begin
                idx = n; f = 1;
              end
              n++;
            end
    end
    tn = idx / 16;
    if (spl) begin
      b = (tn % 2) ? b1 : b0;
      eidx = (tn / 2) * 16 + idx % 16;
    end else begin
      b = b0;
      eidx = idx;
    end
    sz = (bpp == 0) ? 1 : (bpp == 1) ? 2 : 4;
    return b + 32'(eidx * sz);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  // cycle model, sampled in the low half of the clock
  always @(negedge clk) begin
    if (mon_on) begin
      automatic bit exp_ov = (exp_q.size() > 0) && (cyc - acc_q[0] >= 2);
      automatic bit exp_ir = (exp_q.size() < 2) || out_ready;
      chk(out_valid == exp_ov, "R8", 32'(out_valid), 32'(exp_ov));
      chk(in_ready == exp_ir, "R7", 32'(in_ready), 32'(exp_ir));
      if (hold_prev) chk(out_valid && out_addr == prev_addr, "R6", out_addr, prev_addr);
      hold_prev = out_valid && !out_ready;
      prev_addr = out_addr;
      if (out_valid && out_ready && exp_q.size() > 0) begin
        chk(out_addr == exp_q[0], tag_q[0], out_addr, exp_q[0]);
        void'(exp_q.pop_front()); void'(acc_q.pop_front()); void'(tag_q.pop_front());
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(int'(in_x), int'(in_y), int'(in_wst), in_super, in_split,
                              int'(in_bpp), in_base0, in_base1));
        acc_q.push_back(cyc);
        tag_q.push_back(tag_cur);
      end
      cyc++;
    end
  end

  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = rdy_rand ? ($urandom % 3 != 0) : rdy_force;
    end
  end

  task automatic send(int x, int y, int wst, bit sup, bit spl, int bpp,
                      logic [31:0] b0, logic [31:0] b1, string tag);
    in_x = 14'(x); in_y = 14'(y); in_wst = 8'(wst); in_super = sup; in_split = spl;
    in_bpp = 2'(bpp); in_base0 = b0; in_base1 = b1; tag_cur = tag; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  int px_tab[12] = '{4, 7, 8, 0, 4, 0, 56, 63, 64, 127, 0, 70};
  int py_tab[12] = '{0, 3, 0, 4, 12, 16, 60, 63, 0, 5, 64, 100};

  initial begin
    in_valid = 0; in_x = 0; in_y = 0; in_wst = 1; in_super = 1; in_split = 0;
    in_bpp = 2; in_base0 = 0; in_base1 = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9", {30'd0, out_valid, in_ready}, 32'h1);
    @(posedge clk); #1 rst_n = 1'b1;
    mon_on = 1;
    // R1: tile-local ordering
    for (int i = 0; i < 16; i++) send(i % 4, i / 4, 2, 1, 0, 2, 32'h1000, 0, "R1");
    // R2: nested super-tile points
    for (int i = 0; i < 12; i++) send(px_tab[i], py_tab[i], 2, 1, 0, 2, 32'h1000, 0, "R2");
    // R3: flat tiled layout
    for (int i = 0; i < 12; i++) send(px_tab[i], py_tab[i], 2, 0, 0, 2, 32'h2000, 0, "R3");
    send(127, 127, 2, 0, 0, 0, 32'h2000, 0, "R3");
    // R4: split layout, both layouts
    for (int i = 0; i < 12; i++) begin
      send(px_tab[i], py_tab[i], 2, 1, 1, 2, 32'h3000, 32'h80000, "R4");
      send(px_tab[i], py_tab[i], 2, 0, 1, 1, 32'h3000, 32'h80000, "R4");
    end
    // R5: element size codes, including wrap of the address
    for (int b = 0; b < 4; b++) begin
      send(13, 21, 3, 1, 0, b, 32'h4000, 0, "R5");
      send(13, 21, 3, 0, 1, b, 32'hFFFF_FF00, 32'h10, "R5");
    end
    drain();
    // random traffic with back-pressure
    rdy_rand = 1;
    for (int i = 0; i < 200; i++) begin
      automatic int w = 1 + $urandom % 3;
      automatic bit s = $urandom % 2;
      automatic bit p = $urandom % 2;
      send($urandom % (w * 64), $urandom % 128, w, s, p, $urandom % 4,
           $urandom, $urandom, p ? "R4" : (s ? "R2" : "R3"));
    end
    rdy_rand = 0;
    drain();
    // full stall: output held, input blocked after two requests (R6, R7)
    rdy_force = 0;
    fork
      begin
        send(5, 9, 1, 1, 0, 2, 32'h500, 0, "R7");
        send(17, 33, 1, 1, 1, 1, 32'h600, 32'h700, "R7");
        send(60, 2, 1, 0, 0, 0, 32'h800, 0, "R7");
      end
      begin
        repeat (10) @(posedge clk);
        #1 rdy_force = 1;
      end
    join
    drain();
    mon_on = 0;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired R7 actual=%0d expected=0", exp_q.size());
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule